// File: doc/BRIEF.md
# Sub-addressed I2C register target

This block is an I2C target that gives a host access to one control word and two banks of 16-bit user registers. The host reaches them with multi-byte commands. A command byte called the sub-address follows the device address and picks the destination. The control word takes its two data bytes at once. A bank access first carries a 16-bit register address and then a 16-bit data word. All multi-byte values travel high byte first, and each byte is sent most significant bit first.

A read begins like a write: the device address with the direction bit clear, the sub-address, and (for a bank) the register address. The host then issues a repeated start with the read form of the device address, and the block shifts out the high byte and then the low byte of the selected value. Setting the top bit of the control word holds the rest of the device in reset, and all bank registers stay at zero while it is held. Bank A is write-only toward the bus and its contents leave on a parallel output. Bank B can be read back.

SCL and SDA are sampled on a system clock that runs at least eight times the SCL rate. SDA is driven open-drain through an output-enable, where a high enable pulls the line low.

Top module: `i2c_subaddr_regbank`

## Requirements
- R1: The 7-bit device address follows `addr_sel`: 0 or 3 gives 0x40 (bytes 0x80/0x81), 1 gives 0x42 (0x84/0x85), 2 gives 0x44 (0x88/0x89). An address byte that does not match is NACKed, and every later byte is NACKed until the next start.
- R2: Sub-address 0x00 selects the control word, 0x10 writes bank A, 0x11 reads bank A, 0x12 writes bank B and 0x13 reads bank B. Any other sub-address is NACKed, and the rest of the transfer is ignored until the next start.
- R3: A bank write is device address, sub-address, register address high then low, data high then low, and every byte is ACKed. Bank A register n appears on `bank_a_q[16n+15:16n]`.
- R4: A register changes only after its second data byte has been received and ACKed. A stop or a repeated start that comes earlier leaves every register unchanged.
- R5: After a repeated start with the read byte, the block returns the high data byte and then the low one. A master NACK after a byte ends the transmission and releases SDA.
- R6: Bank B implements register addresses 0x0000 to 0x000F and can be read back. Reads of any other address return 0x0000, and writes to them are dropped.
- R7: Reads through sub-address 0x11 always return 0x0000. Values written to bank A cannot be read back over the bus.
- R8: The two data bytes that follow sub-address 0x00 go straight into the control word. `ctrl_q` shows it, and the sequence 0x00 followed by a repeated-start read returns it.
- R9: While control bit 15 is set, `dev_reset` is high, all registers of both banks read as zero, and bank writes have no effect. Writing 0x0000 to the control word ends the hold.
- R10: After `rst_n` the control word and all bank registers are 0x0000 and `sda_oe` is low.
- R11: `sda_oe` changes only while the synchronized SCL is low, except when a start or a stop releases it. After a stop, `sda_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_sel | input | 2 | Strap that picks the device address |
| scl_i | input | 1 | SCL line as seen at the pin |
| sda_i | input | 1 | SDA line as seen at the pin |
| sda_oe | output | 1 | High pulls SDA low (open-drain drive) |
| dev_reset | output | 1 | Reset hold for the processing behind the registers (control bit 15) |
| ctrl_q | output | 16 | Current control word |
| bank_a_q | output | 16*NREG | Bank A registers, register n in bits 16n+15:16n |

## Verification
Two cases are hard to reach from the pins. The first is a write that is cut off between its two data bytes. The second is a read whose first returned byte the master refuses. Both require the master to break a well-formed command partway through. The bench drives the bus with byte-level tasks that it can stop, restart or NACK at any byte boundary. After each broken sequence it follows with a complete read of the same register, which shows that nothing was committed. It also checks that the block has let go of SDA before the next transfer begins.

// File: rtl/i2c_subaddr_regbank.sv
`timescale 1ns/1ps
module i2c_subaddr_regbank #(
  parameter int NREG = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         addr_sel,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe,
  output logic               dev_reset,
  output logic [15:0]        ctrl_q,
  output logic [16*NREG-1:0] bank_a_q
);
  localparam int AW = $clog2(NREG);

  typedef enum logic [2:0] {ST_IDLE, ST_DEV, ST_SUB, ST_RAH, ST_RAL, ST_DH, ST_DL, ST_TX} st_t;

  logic [1:0] scl_sy, sda_sy;
  logic       scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= 2'b11; sda_sy <= 2'b11; scl_d <= 1'b1; sda_d <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_d  <= scl_sy[1];
      sda_d  <= sda_sy[1];
    end

  wire scl_s     = scl_sy[1];
  wire sda_s     = sda_sy[1];
  wire scl_rise  = scl_s & ~scl_d;
  wire scl_fall  = ~scl_s & scl_d;
  wire start_det = scl_s & scl_d & sda_d & ~sda_s;
  wire stop_det  = scl_s & scl_d & ~sda_d & sda_s;

  logic [6:0] dev_addr;
  always_comb
    case (addr_sel)
      2'd1:    dev_addr = 7'h42;
      2'd2:    dev_addr = 7'h44;
      default: dev_addr = 7'h40;
    endcase

  st_t         state;
  logic [3:0]  cnt;
  logic [7:0]  sh, sub, dh;
  logic [15:0] ra, wdata, txsh, rd_word;
  logic        pend, rd_armed, tx_load, tx_second, mack;
  logic [15:0] bank_a [NREG];
  logic [15:0] bank_b [NREG];
  logic [NREG-1:0] b_nz;

  wire fall8  = scl_fall && cnt == 4'd8;
  wire fall9  = scl_fall && cnt == 4'd9;
  wire sub_ok = sh == 8'h00 || sh == 8'h10 || sh == 8'h11 || sh == 8'h12 || sh == 8'h13;
  wire ra_hit = ra[15:AW] == '0;
  wire [AW-1:0] ra_idx = ra[AW-1:0];
  wire commit = fall9 && pend;

  assign dev_reset = ctrl_q[15];

  always_comb
    case (sub)
      8'h00:   rd_word = ctrl_q;
      8'h13:   rd_word = ra_hit ? bank_b[ra_idx] : 16'h0000;
      default: rd_word = 16'h0000;
    endcase

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; cnt <= '0; sh <= '0; sub <= '0; dh <= '0; ra <= '0;
      wdata <= '0; txsh <= '0; pend <= 1'b0; rd_armed <= 1'b0; tx_load <= 1'b0;
      tx_second <= 1'b0; mack <= 1'b0; sda_oe <= 1'b0; ctrl_q <= '0;
    end else if (start_det) begin
      state <= ST_DEV; cnt <= '0; sda_oe <= 1'b0; pend <= 1'b0;
    end else if (stop_det) begin
      state <= ST_IDLE; cnt <= '0; sda_oe <= 1'b0; pend <= 1'b0; rd_armed <= 1'b0;
    end else if (scl_rise) begin
      if (cnt < 4'd8) sh <= {sh[6:0], sda_s};
      else            mack <= ~sda_s;
      cnt <= cnt + 4'd1;
    end else if (fall8) begin
      sda_oe <= 1'b0;
      case (state)
        ST_DEV:
          if (sh[7:1] == dev_addr && (!sh[0] || rd_armed)) begin
            sda_oe <= 1'b1;
            if (sh[0]) begin
              state <= ST_TX; txsh <= rd_word; tx_load <= 1'b1; tx_second <= 1'b0;
            end else begin
              state <= ST_SUB; rd_armed <= 1'b0;
            end
          end else begin
            state <= ST_IDLE; rd_armed <= 1'b0;
          end
        ST_SUB:
          if (sub_ok) begin
            sda_oe <= 1'b1; sub <= sh;
            if (sh == 8'h00) begin state <= ST_DH; rd_armed <= 1'b1; end
            else state <= ST_RAH;
          end else state <= ST_IDLE;
        ST_RAH: begin sda_oe <= 1'b1; ra[15:8] <= sh; state <= ST_RAL; end
        ST_RAL: begin
          sda_oe <= 1'b1; ra[7:0] <= sh;
          if (sub[0]) begin rd_armed <= 1'b1; state <= ST_IDLE; end
          else state <= ST_DH;
        end
        ST_DH: begin sda_oe <= 1'b1; dh <= sh; state <= ST_DL; end
        ST_DL: begin sda_oe <= 1'b1; wdata <= {dh, sh}; pend <= 1'b1; end
        default: ;
      endcase
    end else if (fall9) begin
      cnt <= '0; sda_oe <= 1'b0;
      if (pend) begin
        pend <= 1'b0; state <= ST_IDLE;
        if (sub == 8'h00) ctrl_q <= wdata;
      end
      if (state == ST_TX) begin
        if (tx_load) begin
          tx_load <= 1'b0; sda_oe <= ~txsh[15];
        end else if (mack && !tx_second) begin
          tx_second <= 1'b1; txsh <= {txsh[14:0], 1'b0}; sda_oe <= ~txsh[14];
        end else state <= ST_IDLE;
      end
    end else if (scl_fall && state == ST_TX && cnt != 4'd0) begin
      txsh <= {txsh[14:0], 1'b0}; sda_oe <= ~txsh[14];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin bank_a[i] <= '0; bank_b[i] <= '0; end
    end else if (ctrl_q[15]) begin
      for (int i = 0; i < NREG; i++) begin bank_a[i] <= '0; bank_b[i] <= '0; end
    end else if (commit && ra_hit) begin
      if (sub == 8'h10) bank_a[ra_idx] <= wdata;
      if (sub == 8'h12) bank_b[ra_idx] <= wdata;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign bank_a_q[16*g +: 16] = bank_a[g];
    assign b_nz[g] = |bank_b[g];
  end

  assert_hold_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[15] |=> (bank_a_q == '0 && b_nz == '0));

  assert_commit_path_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bank_a_q) |-> ($past(ctrl_q[15]) || $past(state == ST_DL)));

  assert_oe_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> (!$past(scl_s) || $past(start_det) || $past(stop_det)));

  assert_stop_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  assert_sub_nack_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SUB && fall8 && !sub_ok) |=> (!sda_oe && state == ST_IDLE));
endmodule

// File: tb/i2c_subaddr_regbank_test.sv
`timescale 1ns/1ps
module i2c_subaddr_regbank_test;
  localparam int NREG = 16;
  localparam int Q = 40;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, m_oe = 1'b0;
  logic [1:0] addr_sel = 2'd0;
  logic sda_oe, dev_reset;
  logic [15:0] ctrl_q;
  logic [16*NREG-1:0] bank_a_q;
  wire sda = ~(m_oe | sda_oe);

  i2c_subaddr_regbank #(.NREG(NREG)) uut (
    .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel), .scl_i(scl), .sda_i(sda),
    .sda_oe(sda_oe), .dev_reset(dev_reset), .ctrl_q(ctrl_q), .bank_a_q(bank_a_q));

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  logic [7:0] devw = 8'h80;

  typedef struct { logic [15:0] v; string tag; } item_t;
  item_t exp_q[$];
  logic [15:0] obs_q[$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial forever begin
    @(negedge clk);
    while (exp_q.size() > 0 && obs_q.size() > 0) begin
      item_t e;
      logic [15:0] o;
      e = exp_q.pop_front();
      o = obs_q.pop_front();
      chk(o == e.v, e.tag, {16'h0, o}, {16'h0, e.v});
    end
  end

  task automatic start_c;
    m_oe = 1'b0; #(Q); scl = 1'b1; #(Q); m_oe = 1'b1; #(Q); scl = 1'b0; #(Q);
  endtask

  task automatic stop_c;
    m_oe = 1'b1; #(Q); scl = 1'b1; #(Q); m_oe = 1'b0; #(Q);
  endtask

  task automatic wbyte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_oe = ~b[i]; #(Q); scl = 1'b1; #(2*Q); scl = 1'b0; #(Q);
    end
    m_oe = 1'b0; #(Q); scl = 1'b1; #(Q); ack = ~sda; #(Q); scl = 1'b0; #(Q);
  endtask

  task automatic rbyte(input bit ack_it, output logic [7:0] b);
    m_oe = 1'b0;
    for (int i = 0; i < 8; i++) begin
      #(Q); scl = 1'b1; #(Q); b = {b[6:0], sda}; #(Q); scl = 1'b0;
    end
    #(Q); m_oe = ack_it; #(Q); scl = 1'b1; #(2*Q); scl = 1'b0; #(Q); m_oe = 1'b0;
  endtask

  task automatic write16(input logic [7:0] sub, input logic [15:0] ra, input logic [15:0] d,
                         input string tag);
    bit a, all;
    @(negedge clk);
    all = 1'b1;
    start_c;
    wbyte(devw, a); all &= a;
    wbyte(sub, a); all &= a;
    if (sub != 8'h00) begin wbyte(ra[15:8], a); all &= a; wbyte(ra[7:0], a); all &= a; end
    wbyte(d[15:8], a); all &= a;
    wbyte(d[7:0], a); all &= a;
    stop_c;
    chk(all, tag, {31'h0, all}, 32'h1);
    chk(!sda_oe, {tag, " R11 released after stop"}, {31'h0, sda_oe}, 32'h0);
  endtask

  task automatic read16(input logic [7:0] sub, input logic [15:0] ra, input logic [15:0] expv,
                        input string tag);
    bit a, all;
    logic [7:0] hi, lo;
    item_t e;
    @(negedge clk);
    all = 1'b1;
    start_c;
    wbyte(devw, a); all &= a;
    wbyte(sub, a); all &= a;
    if (sub != 8'h00) begin wbyte(ra[15:8], a); all &= a; wbyte(ra[7:0], a); all &= a; end
    start_c;
    wbyte(devw | 8'h01, a); all &= a;
    rbyte(1'b1, hi);
    rbyte(1'b0, lo);
    stop_c;
    chk(all, {tag, " acks"}, {31'h0, all}, 32'h1);
    e.v = expv; e.tag = tag;
    exp_q.push_back(e);
    obs_q.push_back({hi, lo});
  endtask

  initial begin
    #(800000);
    fails++;
    $display("FAIL watchdog R10 actual=%h expected=%h", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    bit a, b2;
    logic [7:0] hi;
    repeat (5) @(negedge clk);
    chk(!sda_oe && ctrl_q == 16'h0 && bank_a_q == '0, "R10 state during reset",
        {15'h0, sda_oe, ctrl_q}, 32'h0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!sda_oe && ctrl_q == 16'h0 && bank_a_q == '0 && !dev_reset, "R10 state after reset",
        {15'h0, sda_oe, ctrl_q}, 32'h0);

    write16(8'h12, 16'h0003, 16'hA5C3, "R3 bank B write acks");
    read16(8'h13, 16'h0003, 16'hA5C3, "R5 R6 bank B readback");

    write16(8'h10, 16'h0005, 16'h1234, "R3 bank A write acks");
    chk(bank_a_q[16*5 +: 16] == 16'h1234, "R3 bank A reg 5", bank_a_q[16*5 +: 16], 16'h1234);
    read16(8'h11, 16'h0005, 16'h0000, "R7 bank A not readable");

    write16(8'h00, 16'h0000, 16'h0123, "R8 control write acks");
    chk(ctrl_q == 16'h0123, "R8 ctrl_q", ctrl_q, 16'h0123);
    read16(8'h00, 16'h0000, 16'h0123, "R8 control readback");

    write16(8'h12, 16'h0103, 16'hFFFF, "R6 out-of-range write acks");
    read16(8'h13, 16'h0003, 16'hA5C3, "R6 out-of-range write dropped");
    read16(8'h13, 16'h0103, 16'h0000, "R6 out-of-range read zero");

    @(negedge clk);
    start_c; wbyte(8'h84, a); wbyte(8'h12, b2); stop_c;
    chk(!a, "R1 foreign address NACK", {31'h0, a}, 32'h0);
    chk(!b2, "R1 later byte ignored", {31'h0, b2}, 32'h0);

    @(negedge clk);
    start_c; wbyte(8'h80, a); wbyte(8'h14, a); wbyte(8'h00, b2); stop_c;
    chk(!a, "R2 invalid sub-address NACK", {31'h0, a}, 32'h0);
    chk(!b2, "R2 rest ignored", {31'h0, b2}, 32'h0);

    @(negedge clk);
    start_c; wbyte(8'h80, a); wbyte(8'h12, a); wbyte(8'h00, a); wbyte(8'h04, a);
    wbyte(8'hBE, a); stop_c;
    read16(8'h13, 16'h0004, 16'h0000, "R4 stop before low byte");
    @(negedge clk);
    start_c; wbyte(8'h80, a); wbyte(8'h10, a); wbyte(8'h00, a); wbyte(8'h05, a);
    wbyte(8'hBE, a); start_c; wbyte(8'h80, a); wbyte(8'h12, a); wbyte(8'h00, a);
    wbyte(8'h04, a); stop_c;
    chk(bank_a_q[16*5 +: 16] == 16'h1234, "R4 restart abandons write", bank_a_q[16*5 +: 16], 16'h1234);

    @(negedge clk);
    start_c; wbyte(8'h80, a); wbyte(8'h13, a); wbyte(8'h00, a); wbyte(8'h03, a);
    start_c; wbyte(8'h81, a); rbyte(1'b0, hi);
    chk(hi == 8'hA5, "R5 high byte first", hi, 8'hA5);
    repeat (4) @(negedge clk);
    chk(!sda_oe, "R5 release after master NACK", {31'h0, sda_oe}, 32'h0);
    stop_c;

    write16(8'h00, 16'h0000, 16'h8000, "R9 hold write acks");
    chk(dev_reset && bank_a_q == '0, "R9 hold clears bank A", {dev_reset, bank_a_q[16*5 +: 16]}, 32'h10000);
    write16(8'h10, 16'h0005, 16'h7777, "R9 write during hold acks");
    chk(bank_a_q == '0, "R9 bank A write ignored", bank_a_q[16*5 +: 16], 16'h0);
    read16(8'h13, 16'h0003, 16'h0000, "R9 bank B cleared");
    write16(8'h00, 16'h0000, 16'h0000, "R9 release acks");
    chk(!dev_reset, "R9 hold released", {31'h0, dev_reset}, 32'h0);
    write16(8'h12, 16'h0003, 16'h5A5A, "R9 write after release acks");
    read16(8'h13, 16'h0003, 16'h5A5A, "R9 bank B usable again");

    addr_sel = 2'd2;
    @(negedge clk);
    start_c; wbyte(8'h80, a); stop_c;
    chk(!a, "R1 0x80 NACK with select 2", {31'h0, a}, 32'h0);
    devw = 8'h88;
    write16(8'h10, 16'h0001, 16'hBEEF, "R1 0x88 write acks");
    chk(bank_a_q[16 +: 16] == 16'hBEEF, "R1 R3 bank A reg 1", bank_a_q[16 +: 16], 16'hBEEF);
    addr_sel = 2'd1; devw = 8'h84;
    read16(8'h00, 16'h0000, 16'h0000, "R1 R8 read via 0x84/0x85");
    addr_sel = 2'd3; devw = 8'h80;
    read16(8'h13, 16'h0003, 16'h5A5A, "R1 select 3 uses 0x80");

    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0 && obs_q.size() == 0, "R5 scoreboard drained",
        exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule